// File: doc/BRIEF.md
# Erase-Triggered Wear-Leveling Swap Sequencer

This block sits between a host erase command and a flash operation engine. A command names a logical sector. The block looks up the physical sector that currently backs it and has that sector erased. It then bumps that sector's erase counter. If the new count is above a threshold and the logical sector belongs to the wear-leveling pool, the block starts a swap. It scans the pool one sector per cycle for the least-worn physical sector and then drives a fixed, checkpointed sequence of flash operations around a single atomic update of the RAM mapping table.

Logical and physical sectors with an index below `RET_SECT` form the long-retention partition. They always map to themselves and never take part in a swap. All other sectors form the pool. The block holds the RAM mapping table (both directions) and the per-sector erase counters. Both can be read through lookup ports, and every table write is also shown on a write port for a mirror or a log.

Top module: `wl_swap_seq`

## Requirements
- R1: On an accepted command for logical sector A, the first flash request is an erase (op code 0) of the physical sector X that A currently maps to. When no swap follows, no further request is made and `busy` drops two cycles after that erase is acknowledged.
- R2: Every acknowledged erase request (op 0) raises the erase counter of the physical sector named in `fop_sect` by exactly one, as seen on `cnt_val`.
- R3: A swap starts only when X's count after the erase is strictly greater than `THRESH` and A is a pool sector. The candidate Y is the pool sector other than X with the lowest count. A tie goes to the lowest index.
- R4: A logical sector with an index below `RET_SECT` is never swapped, whatever its count. Its mapping stays equal to its own index, and no table write ever names a retention sector.
- R5: A swap issues, in this order: program mapping table (op 1, sect X), validation flag 1 (op 2, sect X), copy (op 3, destination `fop_sect`=X, source `fop_src`=Y), validation flag 2 (op 4, sect X), erase (op 0, sect Y), validation flag 3 (op 5, sect X).
- R6: The RAM mapping table does not change before validation flag 2 is acknowledged. `tbl_we` pulses for one cycle, in the cycle right after that acknowledge and before the erase of Y is requested.
- R7: After a swap, A maps to Y and B maps to X, where B is the logical sector that mapped to Y before the swap. The write port shows (A,Y) and (B,X) during `tbl_we`.
- R8: `busy` is high from the cycle after a command is accepted until the sequence ends. A `cmd_valid` pulse while `busy` is high is ignored and causes no extra request.
- R9: A flash request stays high, with a steady op code and sector, until `fop_ack` is seen. Each acknowledge advances the sequence by exactly one step.
- R10: After reset, `busy`, `fop_req` and `tbl_we` are low, every logical sector maps to its own index, and all counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Erase command strobe, accepted when not busy |
| cmd_lsect | input | SW | Logical sector to erase |
| busy | output | 1 | Command in progress |
| fop_req | output | 1 | Flash operation request |
| fop_op | output | 3 | Operation code: 0 erase, 1 map program, 2 flag 1, 3 copy, 4 flag 2, 5 flag 3 |
| fop_sect | output | SW | Target physical sector (copy destination) |
| fop_src | output | SW | Copy source physical sector |
| fop_ack | input | 1 | Flash operation done |
| tbl_we | output | 1 | RAM mapping table write strobe |
| tbl_la | output | SW | Erased logical sector |
| tbl_pa | output | SW | Its new physical sector |
| tbl_lb | output | SW | Displaced logical sector |
| tbl_pb | output | SW | Its new physical sector |
| map_lsect | input | SW | Lookup logical sector |
| map_psect | output | SW | Physical sector mapped to `map_lsect` |
| cnt_psect | input | SW | Counter lookup physical sector |
| cnt_val | output | CW | Erase count of `cnt_psect` |

## Verification
The erase request is visible one cycle after the command is accepted, and `busy` rises in that same cycle. Each following request comes one cycle after the previous acknowledge. The exception is the search, which adds a number of cycles equal to the pool size after the threshold check. `tbl_we` appears in the cycle right after the flag 2 acknowledge. Without a swap, `busy` falls two cycles after the erase acknowledge. The bench drives on the falling edge. It waits for each request level, holds the request for a varied number of cycles before it acknowledges, and samples the strobes and `busy` at the exact falling edge that this count predicts. After every command it reads the full map and all counters through the lookup ports and compares them with an arithmetic model.

// File: rtl/wl_pkg.sv
// Shared types for the wear-leveling swap sequencer.
package wl_pkg;
    typedef enum logic [2:0] {
        OP_ERASE = 3'd0,
        OP_PMAP  = 3'd1,
        OP_VB1   = 3'd2,
        OP_COPY  = 3'd3,
        OP_VB2   = 3'd4,
        OP_VB3   = 3'd5
    } fop_e;

    typedef enum logic [3:0] {
        S_IDLE, S_ERX, S_CHK, S_SRCH, S_PMAP, S_VB1,
        S_COPY, S_VB2, S_UPD, S_ERY, S_VB3
    } st_e;
endpackage

// File: rtl/wl_map_table.sv
// Logical-to-physical sector table with its inverse.
// Assumes writes always exchange two distinct pairs, so the table stays a permutation.
module wl_map_table #(
    parameter int N  = 16,
    parameter int SW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [SW-1:0] la,
    input  logic [SW-1:0] pa,
    input  logic [SW-1:0] lb,
    input  logic [SW-1:0] pb,
    input  logic [SW-1:0] q0_l,
    output logic [SW-1:0] q0_p,
    input  logic [SW-1:0] q1_l,
    output logic [SW-1:0] q1_p,
    input  logic [SW-1:0] q2_p,
    output logic [SW-1:0] q2_l
);
    logic [SW-1:0] fwd [N];
    logic [SW-1:0] inv [N];

    // Identity on reset; a write updates both pairs in both directions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                fwd[i] <= SW'(i);
                inv[i] <= SW'(i);
            end
        end else if (we) begin
            fwd[la] <= pa;
            fwd[lb] <= pb;
            inv[pa] <= la;
            inv[pb] <= lb;
        end
    end

    // Combinational lookups.
    always_comb begin
        q0_p = fwd[q0_l];
        q1_p = fwd[q1_l];
        q2_l = inv[q2_p];
    end

    assert_pair_distinct_R7: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> (la != lb) && (pa != pb));
endmodule

// File: rtl/wl_erase_cnt.sv
// Per-physical-sector erase counters, saturating at all ones.
// Assumes one increment at most per cycle.
module wl_erase_cnt #(
    parameter int N  = 16,
    parameter int SW = 4,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    input  logic [SW-1:0] inc_idx,
    input  logic [SW-1:0] rd0_idx,
    output logic [CW-1:0] rd0,
    input  logic [SW-1:0] rd1_idx,
    output logic [CW-1:0] rd1
);
    logic [CW-1:0] cnt [N];

    // Clear on reset; add one to the addressed counter on an increment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) cnt[i] <= '0;
        end else if (inc && cnt[inc_idx] != '1) begin
            cnt[inc_idx] <= cnt[inc_idx] + 1'b1;
        end
    end

    // Combinational read ports.
    always_comb begin
        rd0 = cnt[rd0_idx];
        rd1 = cnt[rd1_idx];
    end
endmodule

// File: rtl/wl_min_find.sv
// Scans pool sectors LO..N-1, one per cycle, for the lowest count, skipping one index.
// Strict less-than keeps the lowest index on ties. Assumes the pool holds at least two sectors.
module wl_min_find #(
    parameter int N  = 16,
    parameter int LO = 4,
    parameter int SW = 4,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [SW-1:0] skip,
    output logic [SW-1:0] scan_idx,
    input  logic [CW-1:0] scan_cnt,
    output logic          done,
    output logic [SW-1:0] best
);
    localparam logic [SW-1:0] LAST  = SW'(N - 1);
    localparam logic [SW-1:0] FIRST = SW'(LO);

    logic          run;
    logic          have;
    logic [CW-1:0] best_c;

    // Walk the pool and keep the running minimum.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run      <= 1'b0;
            have     <= 1'b0;
            done     <= 1'b0;
            scan_idx <= FIRST;
            best     <= FIRST;
            best_c   <= '0;
        end else begin
            done <= 1'b0;
            if (start) begin
                run      <= 1'b1;
                have     <= 1'b0;
                scan_idx <= FIRST;
            end else if (run) begin
                if (scan_idx != skip && (!have || scan_cnt < best_c)) begin
                    best   <= scan_idx;
                    best_c <= scan_cnt;
                    have   <= 1'b1;
                end
                if (scan_idx == LAST) begin
                    run  <= 1'b0;
                    done <= 1'b1;
                end else begin
                    scan_idx <= scan_idx + 1'b1;
                end
            end
        end
    end

    assert_skip_self_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (best != skip) && have && (best >= FIRST));
endmodule

// File: rtl/wl_swap_seq.sv
// Erase command sequencer with threshold-triggered wear-leveling swap.
// Runs the erase of the mapped sector, checks its count, and on a swap runs
// search, map program, flag 1, copy, flag 2, RAM update, erase of Y, flag 3.
// Assumes fop_ack is only given while fop_req is high.
module wl_swap_seq
    import wl_pkg::*;
#(
    parameter int NUM_SECT = 16,
    parameter int RET_SECT = 4,
    parameter int CNT_W    = 16,
    parameter int THRESH   = 1000,
    localparam int SW      = $clog2(NUM_SECT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [SW-1:0]    cmd_lsect,
    output logic             busy,
    output logic             fop_req,
    output logic [2:0]       fop_op,
    output logic [SW-1:0]    fop_sect,
    output logic [SW-1:0]    fop_src,
    input  logic             fop_ack,
    output logic             tbl_we,
    output logic [SW-1:0]    tbl_la,
    output logic [SW-1:0]    tbl_pa,
    output logic [SW-1:0]    tbl_lb,
    output logic [SW-1:0]    tbl_pb,
    input  logic [SW-1:0]    map_lsect,
    output logic [SW-1:0]    map_psect,
    input  logic [SW-1:0]    cnt_psect,
    output logic [CNT_W-1:0] cnt_val
);
    localparam logic [CNT_W-1:0] THR   = CNT_W'(THRESH);
    localparam logic [SW-1:0]    RET_L = SW'(RET_SECT);

    st_e           st, st_n;
    fop_e          op_c;
    logic [SW-1:0] a_q, x_q, y_q;
    logic [SW-1:0] x_lookup, b_lookup;
    logic [SW-1:0] scan_idx, best;
    logic [CNT_W-1:0] cnt0;
    logic          srch_done, swap_go, step;

    // Next-state logic for the ordered sequence.
    always_comb begin
        st_n = st;
        case (st)
            S_IDLE: if (cmd_valid) st_n = S_ERX;
            S_ERX:  if (fop_ack) st_n = S_CHK;
            S_CHK:  st_n = swap_go ? S_SRCH : S_IDLE;
            S_SRCH: if (srch_done) st_n = S_PMAP;
            S_PMAP: if (fop_ack) st_n = S_VB1;
            S_VB1:  if (fop_ack) st_n = S_COPY;
            S_COPY: if (fop_ack) st_n = S_VB2;
            S_VB2:  if (fop_ack) st_n = S_UPD;
            S_UPD:  st_n = S_ERY;
            S_ERY:  if (fop_ack) st_n = S_VB3;
            S_VB3:  if (fop_ack) st_n = S_IDLE;
            default: st_n = S_IDLE;
        endcase
    end

    // Request level and op code per state.
    always_comb begin
        fop_req = 1'b1;
        op_c    = OP_ERASE;
        case (st)
            S_ERX, S_ERY: op_c = OP_ERASE;
            S_PMAP:       op_c = OP_PMAP;
            S_VB1:        op_c = OP_VB1;
            S_COPY:       op_c = OP_COPY;
            S_VB2:        op_c = OP_VB2;
            S_VB3:        op_c = OP_VB3;
            default:      fop_req = 1'b0;
        endcase
    end

    assign fop_op   = op_c;
    assign fop_sect = (st == S_ERY) ? y_q : x_q;
    assign fop_src  = y_q;
    assign busy     = (st != S_IDLE);
    assign step     = fop_req && fop_ack;
    assign swap_go  = (st == S_CHK) && (a_q >= RET_L) && (cnt0 > THR);
    assign tbl_we   = (st == S_UPD);
    assign tbl_la   = a_q;
    assign tbl_pa   = y_q;
    assign tbl_lb   = b_lookup;
    assign tbl_pb   = x_q;

    // State register and latched sector identities.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= S_IDLE;
            a_q <= '0;
            x_q <= '0;
            y_q <= '0;
        end else begin
            st <= st_n;
            if (st == S_IDLE && cmd_valid) begin
                a_q <= cmd_lsect;
                x_q <= x_lookup;
            end
            if (st == S_SRCH && srch_done) y_q <= best;
        end
    end

    wl_map_table #(.N(NUM_SECT), .SW(SW)) u_map (
        .clk(clk), .rst_n(rst_n), .we(tbl_we),
        .la(tbl_la), .pa(tbl_pa), .lb(tbl_lb), .pb(tbl_pb),
        .q0_l(cmd_lsect), .q0_p(x_lookup),
        .q1_l(map_lsect), .q1_p(map_psect),
        .q2_p(y_q), .q2_l(b_lookup)
    );

    wl_erase_cnt #(.N(NUM_SECT), .SW(SW), .CW(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n),
        .inc(step && (st == S_ERX || st == S_ERY)), .inc_idx(fop_sect),
        .rd0_idx((st == S_SRCH) ? scan_idx : x_q), .rd0(cnt0),
        .rd1_idx(cnt_psect), .rd1(cnt_val)
    );

    wl_min_find #(.N(NUM_SECT), .LO(RET_SECT), .SW(SW), .CW(CNT_W)) u_find (
        .clk(clk), .rst_n(rst_n), .start(swap_go), .skip(x_q),
        .scan_idx(scan_idx), .scan_cnt(cnt0), .done(srch_done), .best(best)
    );

    assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fop_req && !fop_ack |=> fop_req && $stable(fop_op) && $stable(fop_sect));
    assert_tbl_after_vb2_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_we |-> $past(fop_req && fop_ack && fop_op == 3'(OP_VB2)));
    assert_busy_on_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !busy |=> busy && fop_req && fop_op == 3'(OP_ERASE));
    assert_no_retention_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_we |-> (tbl_la >= RET_L) && (tbl_lb >= RET_L) && (tbl_pa >= RET_L) && (tbl_pb >= RET_L));
    assert_last_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fop_req && fop_ack && fop_op == 3'(OP_VB3) |=> !busy);
endmodule

// File: tb/sim_wl_swap_seq.sv
module sim_wl_swap_seq;
    localparam int CLK_PERIOD = 10;
    localparam int N   = 8;
    localparam int RET = 2;
    localparam int CW  = 8;
    localparam int THR = 3;
    localparam int SW  = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [SW-1:0] cmd_lsect = '0;
    logic          busy, fop_req, tbl_we;
    logic [2:0]    fop_op;
    logic [SW-1:0] fop_sect, fop_src, tbl_la, tbl_pa, tbl_lb, tbl_pb, map_psect;
    logic          fop_ack = 1'b0;
    logic [SW-1:0] map_lsect = '0, cnt_psect = '0;
    logic [CW-1:0] cnt_val;

    int checks = 0;
    int errors = 0;
    int m_fwd [N];
    int m_inv [N];
    int m_cnt [N];

    always #(CLK_PERIOD/2) clk = ~clk;

    wl_swap_seq #(.NUM_SECT(N), .RET_SECT(RET), .CNT_W(CW), .THRESH(THR)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_lsect(cmd_lsect),
        .busy(busy), .fop_req(fop_req), .fop_op(fop_op), .fop_sect(fop_sect),
        .fop_src(fop_src), .fop_ack(fop_ack), .tbl_we(tbl_we), .tbl_la(tbl_la),
        .tbl_pa(tbl_pa), .tbl_lb(tbl_lb), .tbl_pb(tbl_pb), .map_lsect(map_lsect),
        .map_psect(map_psect), .cnt_psect(cnt_psect), .cnt_val(cnt_val)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Full map and counter comparison through the lookup ports.
    task automatic check_state();
        for (int l = 0; l < N; l++) begin
            map_lsect = SW'(l);
            cnt_psect = SW'(l);
            #1;
            chk(int'(map_psect) == m_fwd[l], "R7 map", int'(map_psect), m_fwd[l]);
            chk(int'(cnt_val) == m_cnt[l], "R2 count", int'(cnt_val), m_cnt[l]);
            if (l < RET) chk(int'(map_psect) == l, "R4 retention identity", int'(map_psect), l);
        end
    endtask

    // Wait for a request, check it, hold for dly cycles, then acknowledge.
    task automatic serve(input int op, input int sect, input int src, input int dly,
                         input int lchk, input int old_p, input string req);
        int t = 0;
        while (!fop_req && t < 100) begin
            @(negedge clk);
            t++;
        end
        chk(fop_req == 1'b1, {req, " request"}, int'(fop_req), 1);
        chk(int'(fop_op) == op, {req, " op"}, int'(fop_op), op);
        chk(int'(fop_sect) == sect, {req, " sect"}, int'(fop_sect), sect);
        if (op == 3) chk(int'(fop_src) == src, "R5 copy source", int'(fop_src), src);
        if (lchk >= 0) begin
            map_lsect = SW'(lchk);
            #1;
            chk(int'(map_psect) == old_p, "R6 map held", int'(map_psect), old_p);
            chk(tbl_we == 1'b0, "R6 no early write", int'(tbl_we), 0);
        end
        for (int k = 0; k < dly; k++) begin
            @(negedge clk);
            chk(fop_req == 1'b1 && int'(fop_op) == op, "R9 hold", int'(fop_op), op);
        end
        fop_ack = 1'b1;
        @(negedge clk);
        fop_ack = 1'b0;
    endtask

    task automatic do_erase(input int l, input int dly, input bit rej);
        int x, y, b;
        bit swap;
        x = m_fwd[l];
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_lsect = SW'(l);
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(busy == 1'b1, "R8 busy after accept", int'(busy), 1);
        if (rej) begin
            cmd_valid = 1'b1;
            cmd_lsect = SW'((l + 3) % N);
            @(negedge clk);
            cmd_valid = 1'b0;
        end
        serve(0, x, 0, dly, -1, 0, "R1 erase X");
        m_cnt[x]++;
        swap = (l >= RET) && (m_cnt[x] > THR);
        if (!swap) begin
            chk(busy == 1'b1, "R1 check cycle", int'(busy), 1);
            @(negedge clk);
            chk(busy == 1'b0 && fop_req == 1'b0, "R1 done no swap", int'(busy), 0);
        end else begin
            y = -1;
            for (int p = RET; p < N; p++)
                if (p != x && (y < 0 || m_cnt[p] < m_cnt[y])) y = p;
            b = m_inv[y];
            serve(1, x, 0, dly, l, x, "R5 map program");
            serve(2, x, 0, dly, l, x, "R5 flag1");
            serve(3, x, y, dly, l, x, "R3 R5 copy");
            serve(4, x, 0, dly, l, x, "R5 flag2");
            chk(tbl_we == 1'b1, "R6 write strobe", int'(tbl_we), 1);
            chk(int'(tbl_la) == l && int'(tbl_pa) == y, "R7 pair A", int'(tbl_pa), y);
            chk(int'(tbl_lb) == b && int'(tbl_pb) == x, "R7 pair B", int'(tbl_lb), b);
            serve(0, y, 0, dly, -1, 0, "R5 erase Y");
            m_cnt[y]++;
            serve(5, x, 0, dly, -1, 0, "R5 flag3");
            chk(busy == 1'b0, "R8 busy end", int'(busy), 1'b0);
            m_fwd[l] = y;  m_inv[y] = l;
            m_fwd[b] = x;  m_inv[x] = b;
        end
        if (rej) begin
            repeat (3) begin
                @(negedge clk);
                chk(fop_req == 1'b0 && busy == 1'b0, "R8 ignored command", int'(fop_req), 0);
            end
        end
        check_state();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual 0 expected 1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            m_fwd[i] = i;
            m_inv[i] = i;
            m_cnt[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0 && fop_req == 1'b0 && tbl_we == 1'b0, "R10 reset outputs", int'(busy), 0);
        check_state();
        // Retention sector well beyond the threshold: never swapped.
        for (int i = 0; i < 6; i++) do_erase(0, i % 2, 1'b0);
        do_erase(1, 2, 1'b1);
        // Hammer one pool sector: ties, skip, varied ack delay, rejected commands.
        for (int i = 0; i < 30; i++) do_erase(2, i % 4, (i % 5) == 0);
        // Rounds over every logical sector.
        for (int r = 0; r < 4; r++)
            for (int l = 0; l < N; l++) do_erase(l, (l + r) % 3, (l == 5));
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule